// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block holds the control state of an eight-pin general-purpose I/O port and turns it into pad controls. A small register bus (address, write strobe, write data and combinational read data) reaches three registers: a direction register that picks output or input for each pin, a level register that holds the driven value on output pins and turns on the pull-up on input pins, and a pin-sample address. Reading the pin-sample address returns the live pad level for input pins and the driven level for output pins. Writing ones to it inverts the matching bits of the level register.

A timer compare unit can take over any single pin. It sends a command that forces the pin high, forces it low, inverts the forced level, or releases the pin. Each pin has its own small state machine with three states. FOLLOW means the pin drives its level-register bit. FORCED_HIGH and FORCED_LOW mean it drives a fixed level and ignores the level register. The transitions are as follows. A set command goes from any state to FORCED_HIGH. A clear command goes from any state to FORCED_LOW. A release command goes from any state to FOLLOW. A toggle command moves FORCED_HIGH to FORCED_LOW and FORCED_LOW to FORCED_HIGH. From FOLLOW, a toggle goes to the forced state opposite the current level-register bit.

Any register write produces a one-cycle change event. It carries the new level and direction values, so that models of the pads and of the attached parts can follow the port.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and level registers are 0, no pin is forced, pad_oe is 0, every pin state is 0 (input) and chg_pulse is 0.
- R2: A pin whose direction bit is 1 has pad_oe 1 and drives its effective level on pad_out. Its 2-bit state field (bits 2i+1:2i of pin_state) is 3 when that level is high and 2 when it is low.
- R3: A pin whose direction bit is 0 has pad_oe 0. Its state field is 1 (input with pull-up) when its level-register bit is 1, and 0 (plain input) otherwise.
- R4: Reading address 0 returns, for each bit, the effective driven level if the pin is an output and pad_in if the pin is an input. Switching a pin to input makes the pad level visible at once.
- R5: Writing to address 0 inverts each level-register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: Address 1 reads and writes the direction register and address 2 reads and writes the level register. Address 3 reads 0, and a write to it changes no register and raises no event.
- R7: An override command (ovr_cmd 1 = set, 2 = clear) forces pin ovr_pin high or low. The forced level appears on pad_out, in the pin state and at address 0, and later level-register writes do not affect that pin.
- R8: ovr_cmd 0 (release) makes the pin follow its level-register bit again. ovr_cmd 3 (toggle) inverts the pin's current effective level and holds the new level as forced.
- R9: A write to address 0, 1 or 2 makes chg_pulse 1 for exactly the next cycle, with chg_out and chg_dir equal to the level and direction registers after that write. No pulse appears in a cycle that follows no such write.
- R10: Register writes and override commands take effect on the clock edge that samples them. bus_rdata follows bus_addr combinationally, without any cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 pin sample, 1 direction, 2 level, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | External pad levels |
| pad_out | output | 8 | Effective driven level per pin |
| pad_oe | output | 8 | Output enable per pin |
| pin_state | output | 16 | Two bits per pin: 0 input, 1 pull-up, 2 low, 3 high |
| ovr_valid | input | 1 | Override command strobe |
| ovr_pin | input | 3 | Pin index of the override command |
| ovr_cmd | input | 2 | 0 release, 1 set, 2 clear, 3 toggle |
| chg_pulse | output | 1 | One-cycle change event |
| chg_out | output | 8 | Level register value carried by the event |
| chg_dir | output | 8 | Direction register value carried by the event |

## Verification
A register write or an override command sampled at a rising edge shows on pad_out, pad_oe, pin_state and bus_rdata after that edge, and chg_pulse is high only in the cycle that follows. The bench therefore applies every stimulus at a falling edge and removes it at the next falling edge, then checks at that falling edge. A pulse check is made there and a no-pulse check one cycle later. Read checks set bus_addr and compare within the same low clock phase, which covers the combinational read path.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        PS_INPUT  = 2'd0,
        PS_PULLUP = 2'd1,
        PS_LOW    = 2'd2,
        PS_HIGH   = 2'd3
    } pin_state_e;

    typedef enum logic [1:0] {
        OC_RELEASE = 2'd0,
        OC_SET     = 2'd1,
        OC_CLEAR   = 2'd2,
        OC_TOGGLE  = 2'd3
    } ovr_cmd_e;

    typedef enum logic [1:0] {
        OV_FOLLOW      = 2'd0,
        OV_FORCED_HIGH = 2'd1,
        OV_FORCED_LOW  = 2'd2
    } ovr_state_e;

    localparam logic [1:0] A_PIN = 2'd0;
    localparam logic [1:0] A_DIR = 2'd1;
    localparam logic [1:0] A_LVL = 2'd2;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q,
    output logic         chg_pulse,
    output logic [W-1:0] chg_out,
    output logic [W-1:0] chg_dir
);
    logic [W-1:0] dir_n;
    logic [W-1:0] out_n;
    logic         hit;

    always_comb begin
        dir_n = dir_q;
        out_n = out_q;
        hit   = 1'b0;
        if (we) begin
            unique case (addr)
                A_PIN: begin
                    out_n = out_q ^ wdata;
                    hit   = 1'b1;
                end
                A_DIR: begin
                    dir_n = wdata;
                    hit   = 1'b1;
                end
                A_LVL: begin
                    out_n = wdata;
                    hit   = 1'b1;
                end
                default: hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= '0;
            out_q     <= '0;
            chg_pulse <= 1'b0;
            chg_out   <= '0;
            chg_dir   <= '0;
        end else begin
            dir_q     <= dir_n;
            out_q     <= out_n;
            chg_pulse <= hit;
            if (hit) begin
                chg_out <= out_n;
                chg_dir <= dir_n;
            end
        end
    end
endmodule

// File: rtl/gpio_ovr_fsm.sv
module gpio_ovr_fsm
    import gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic       lvl_bit,
    output logic       force_en,
    output logic       force_lvl
);
    ovr_state_e state_q;
    ovr_state_e state_n;
    ovr_cmd_e   cmd_e;

    assign cmd_e = ovr_cmd_e'(cmd);

    always_comb begin
        state_n = state_q;
        if (cmd_valid) begin
            unique case (cmd_e)
                OC_SET:     state_n = OV_FORCED_HIGH;
                OC_CLEAR:   state_n = OV_FORCED_LOW;
                OC_RELEASE: state_n = OV_FOLLOW;
                OC_TOGGLE: begin
                    unique case (state_q)
                        OV_FORCED_HIGH: state_n = OV_FORCED_LOW;
                        OV_FORCED_LOW:  state_n = OV_FORCED_HIGH;
                        default:        state_n = lvl_bit ? OV_FORCED_LOW : OV_FORCED_HIGH;
                    endcase
                end
                default: state_n = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OV_FOLLOW;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            OV_FORCED_HIGH: begin force_en = 1'b1; force_lvl = 1'b1; end
            OV_FORCED_LOW:  begin force_en = 1'b1; force_lvl = 1'b0; end
            default:        begin force_en = 1'b0; force_lvl = 1'b0; end
        endcase
    end
endmodule

// File: rtl/gpio_pin_view.sv
module gpio_pin_view
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   dir_q,
    input  logic [W-1:0]   out_q,
    input  logic [W-1:0]   force_en,
    input  logic [W-1:0]   force_lvl,
    input  logic [W-1:0]   pad_in,
    input  logic [1:0]     addr,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe,
    output logic [2*W-1:0] pin_state,
    output logic [W-1:0]   rdata
);
    logic [W-1:0] sample;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pad_out[i] = force_en[i] ? force_lvl[i] : out_q[i];
        assign sample[i]  = dir_q[i] ? pad_out[i] : pad_in[i];
        always_comb begin
            if (dir_q[i]) pin_state[2*i +: 2] = pad_out[i] ? PS_HIGH : PS_LOW;
            else          pin_state[2*i +: 2] = out_q[i] ? PS_PULLUP : PS_INPUT;
        end
    end

    assign pad_oe = dir_q;

    always_comb begin
        unique case (addr)
            A_PIN:   rdata = sample;
            A_DIR:   rdata = dir_q;
            A_LVL:   rdata = out_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     bus_addr,
    input  logic           bus_we,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   bus_rdata,
    input  logic [W-1:0]   pad_in,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe,
    output logic [2*W-1:0] pin_state,
    input  logic           ovr_valid,
    input  logic [IW-1:0]  ovr_pin,
    input  logic [1:0]     ovr_cmd,
    output logic           chg_pulse,
    output logic [W-1:0]   chg_out,
    output logic [W-1:0]   chg_dir
);
    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] force_en;
    logic [W-1:0] force_lvl;

    gpio_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .chg_pulse (chg_pulse),
        .chg_out   (chg_out),
        .chg_dir   (chg_dir)
    );

    for (genvar i = 0; i < W; i++) begin : g_ovr
        gpio_ovr_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_valid (ovr_valid && (ovr_pin == IW'(i))),
            .cmd       (ovr_cmd),
            .lvl_bit   (out_q[i]),
            .force_en  (force_en[i]),
            .force_lvl (force_lvl[i])
        );
    end

    gpio_pin_view #(.W(W)) u_view (
        .dir_q     (dir_q),
        .out_q     (out_q),
        .force_en  (force_en),
        .force_lvl (force_lvl),
        .pad_in    (pad_in),
        .addr      (bus_addr),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pin_state (pin_state),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8,
    parameter int IW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     bus_addr,
    input logic           bus_we,
    input logic [W-1:0]   bus_wdata,
    input logic [W-1:0]   pad_out,
    input logic [W-1:0]   pad_oe,
    input logic [2*W-1:0] pin_state,
    input logic           ovr_valid,
    input logic [IW-1:0]  ovr_pin,
    input logic [1:0]     ovr_cmd,
    input logic           chg_pulse,
    input logic [W-1:0]   chg_out,
    input logic [W-1:0]   dir_q,
    input logic [W-1:0]   out_q
);
    // R2, R10: a direction write shows on the enables after the edge
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == 2'd1 |=> pad_oe == $past(bus_wdata));

    // R5: a pin-sample write inverts the selected level bits
    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == 2'd0 |=> out_q == ($past(out_q) ^ $past(bus_wdata)));

    // R6: the unused address leaves both registers alone
    p_unused_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == 2'd3 |=> $stable(out_q) && $stable(dir_q));

    // R7: a set command drives the chosen pin high
    p_force_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid && ovr_cmd == 2'd1 |=> pad_out[$past(ovr_pin)]);

    // R9: a level write raises the event with the written value
    p_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == 2'd2 |=> chg_pulse && chg_out == $past(bus_wdata));

    // R9: no write to a live address, no event
    p_no_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr != 2'd3) |=> !chg_pulse);

    // R3: a pull-up state never comes with an enabled output
    for (genvar i = 0; i < W; i++) begin : g_pu
        p_pullup_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pin_state[2*i +: 2] == 2'd1 |-> !pad_oe[i]);
    end
endmodule

bind gpio_port gpio_port_chk #(.W(W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pin_state (pin_state),
    .ovr_valid (ovr_valid),
    .ovr_pin   (ovr_pin),
    .ovr_cmd   (ovr_cmd),
    .chg_pulse (chg_pulse),
    .chg_out   (chg_out),
    .dir_q     (dir_q),
    .out_q     (out_q)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;
    logic [15:0] pin_state;
    logic        ovr_valid = 1'b0;
    logic [2:0]  ovr_pin = '0;
    logic [1:0]  ovr_cmd = '0;
    logic        chg_pulse;
    logic [7:0]  chg_out;
    logic [7:0]  chg_dir;

    always #5 clk = ~clk;

    gpio_port dut (.*);

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    done_cnt = 0;
    bit    finished = 0;

    // bench model, built from the requirements
    logic [7:0] m_dir = '0, m_out = '0, m_fen = '0, m_flv = '0;

    function automatic logic [7:0] m_drive();
        return (m_fen & m_flv) | (~m_fen & m_out);
    endfunction

    function automatic logic [7:0] m_pin();
        return (m_dir & m_drive()) | (~m_dir & pad_in);
    endfunction

    function automatic logic [15:0] m_state();
        logic [15:0] s;
        logic [7:0]  d;
        d = m_drive();
        for (int i = 0; i < 8; i++) begin
            if (m_dir[i]) s[2*i +: 2] = d[i] ? 2'd3 : 2'd2;
            else          s[2*i +: 2] = m_out[i] ? 2'd1 : 2'd0;
        end
        return s;
    endfunction

    function automatic logic [15:0] observe(int sel);
        case (sel)
            0: return {8'h00, bus_rdata};
            1: return {8'h00, pad_oe};
            2: return {8'h00, pad_out};
            3: return pin_state;
            4: return {15'h0, chg_pulse};
            5: return {8'h00, chg_out};
            default: return {8'h00, chg_dir};
        endcase
    endfunction

    // monitor: pops expected items and compares against the design
    initial begin
        item_t it;
        logic [15:0] act;
        forever begin
            wait (q.size() > 0);
            it = q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
            done_cnt++;
        end
    end

    task automatic expect_item(string req, int sel, logic [15:0] exp);
        int target;
        target = done_cnt + 1;
        q.push_back('{req, sel, exp});
        wait (done_cnt == target);
    endtask

    task automatic expect_read(string req, logic [1:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        expect_item(req, 0, {8'h00, exp});
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            2'd0: m_out = m_out ^ d;
            2'd1: m_dir = d;
            2'd2: m_out = d;
            default: ;
        endcase
    endtask

    task automatic ovr(logic [2:0] p, logic [1:0] c);
        logic [7:0] d;
        d = m_drive();
        @(negedge clk);
        ovr_valid = 1'b1; ovr_pin = p; ovr_cmd = c;
        @(negedge clk);
        ovr_valid = 1'b0;
        case (c)
            2'd0: m_fen[p] = 1'b0;
            2'd1: begin m_fen[p] = 1'b1; m_flv[p] = 1'b1; end
            2'd2: begin m_fen[p] = 1'b1; m_flv[p] = 1'b0; end
            default: begin m_fen[p] = 1'b1; m_flv[p] = ~d[p]; end
        endcase
    endtask

    task automatic check_pins(string req);
        expect_item(req, 1, {8'h00, m_dir});
        expect_item(req, 2, {8'h00, m_drive()});
        expect_item(req, 3, m_state());
        expect_read(req, 2'd0, m_pin());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_item("R1 pin_state", 3, 16'h0000);
        expect_item("R1 pad_oe", 1, 16'h0000);
        expect_item("R1 chg_pulse", 4, 16'h0000);
        expect_read("R1 dir", 2'd1, 8'h00);
        expect_read("R1 lvl", 2'd2, 8'h00);

        // R2 R9 R10 direction write
        wr(2'd1, 8'h0F);
        expect_item("R9 pulse on dir write", 4, 16'h1);
        expect_item("R9 chg_dir", 6, 16'h000F);
        expect_item("R9 chg_out", 5, 16'h0000);
        expect_read("R10 dir read", 2'd1, 8'h0F);
        check_pins("R2 after dir write");
        @(negedge clk);
        expect_item("R9 pulse one cycle", 4, 16'h0);

        // R2 R3 R4 level write
        wr(2'd2, 8'h55);
        expect_item("R9 chg_out level", 5, 16'h0055);
        expect_read("R4 pin read 0x05", 2'd0, 8'h05);
        expect_item("R3 R2 states", 3, m_state());
        check_pins("R2 R3 mixed");
        pad_in = 8'hF0;
        expect_read("R4 pad visible on inputs", 2'd0, 8'hF5);

        // R5 toggle by pin-sample write
        wr(2'd0, 8'h01);
        expect_item("R9 pulse on toggle", 4, 16'h1);
        expect_item("R9 chg_out toggle", 5, 16'h0054);
        expect_read("R5 level after toggle", 2'd2, 8'h54);
        expect_read("R5 pin after toggle", 2'd0, 8'hF4);
        wr(2'd0, 8'h00);
        expect_read("R5 zero write keeps level", 2'd2, 8'h54);

        // R4 switch to input exposes pad
        wr(2'd1, 8'h00);
        expect_read("R4 all inputs", 2'd0, 8'hF0);
        check_pins("R3 pull-ups");

        // R6 unused address
        @(negedge clk);
        wr(2'd3, 8'hFF);
        expect_item("R6 no pulse", 4, 16'h0);
        expect_read("R6 dir kept", 2'd1, 8'h00);
        expect_read("R6 lvl kept", 2'd2, 8'h54);
        expect_read("R6 reads zero", 2'd3, 8'h00);

        // R7 R8 overrides on pin 1
        wr(2'd1, 8'h02);
        ovr(3'd1, 2'd1);
        check_pins("R7 set forces high");
        expect_read("R7 pin reads forced", 2'd0, 8'hF2);
        wr(2'd2, 8'h00);
        check_pins("R7 level write ignored");
        ovr(3'd1, 2'd2);
        check_pins("R7 clear forces low");
        wr(2'd2, 8'h02);
        check_pins("R7 forced low holds");
        ovr(3'd1, 2'd3);
        check_pins("R8 toggle forced");
        ovr(3'd1, 2'd0);
        check_pins("R8 release follows level");
        ovr(3'd1, 2'd3);
        check_pins("R8 toggle from follow");
        ovr(3'd5, 2'd1);
        check_pins("R8 other pin unaffected");

        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule